// File: doc/BRIEF.md
# Descriptor Chain Fetch Unit

This unit serves one channel of a DMA engine that runs from a linked list of transfer descriptors kept in memory. Each descriptor is four consecutive words: a packed control word, a source address, a destination address and a pointer to the next descriptor. When the channel starts a transfer in descriptor mode, the unit reads the four words in turn through a simple request/valid read port. It unpacks the control word into the channel's direction flags and total transfer size, and stores the two addresses. Finally it records which descriptor was just consumed and moves its descriptor pointer on to the next one.

From the control word the unit also derives a chain flag. The flag is set when the descriptor is not the last in its list, so the channel knows whether to load another descriptor when the current transfer finishes. A transfer start outside descriptor mode fetches nothing and clears the chain flag. The descriptor pointer can be loaded from outside while the unit is idle. Bus arbitration and register decoding belong to the surrounding channel logic.

Top module: `desc_fetch`

## Requirements
- R1: After reset every output is zero: `busy_o`, `rd_req_o`, `done_o`, the pointers, the addresses, the size, the flags and `chain_next_o`.
- R2: A `start_i` pulse with `desc_en_i`=1 while idle issues exactly four reads, in this order: pointer+0x0 (control), +0x4 (source), +0x8 (destination), +0xC (next). `busy_o` stays high from the cycle after the start until the last word is taken.
- R3: A read request holds `rd_req_o` high and `rd_addr_o` stable until a cycle in which `rd_valid_i` is high. The word is taken on that clock edge.
- R4: When the control word is taken, `tot_size_o` gets bits [11:0], `inc_src_o` gets bit 16, `inc_dst_o` bit 17, `src_sel_o` bit 18 and `dst_sel_o` bit 19. All are visible in the next cycle.
- R5: When the control word is taken, `chain_next_o` becomes the inverse of control bit 20, which is the end-of-list flag.
- R6: `src_addr_o` is loaded from the second word and `dst_addr_o` from the third.
- R7: When the fourth word is taken, `cur_desc_o` gets the old pointer and `desc_ptr_o` gets the fourth word. In the next cycle `done_o` is high for exactly one cycle and `busy_o` is low.
- R8: A `start_i` pulse with `desc_en_i`=0 while idle clears `chain_next_o`. It issues no read and leaves every other output unchanged.
- R9: While busy, `start_i` and `ptr_we_i` are ignored: no extra reads are issued and the pointer is not overwritten.
- R10: `ptr_we_i` while idle loads `ptr_wdata_i` into `desc_ptr_o`, visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer start pulse |
| desc_en_i | input | 1 | Descriptor mode select for the start |
| ptr_we_i | input | 1 | Descriptor pointer write strobe |
| ptr_wdata_i | input | 32 | Descriptor pointer write value |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 32 | Memory read address |
| rd_valid_i | input | 1 | Read data valid, completes the request |
| rd_data_i | input | 32 | Read data |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle pulse after the fourth word |
| desc_ptr_o | output | 32 | Descriptor pointer |
| cur_desc_o | output | 32 | Address of the descriptor last loaded |
| src_addr_o | output | 32 | Source address |
| dst_addr_o | output | 32 | Destination address |
| tot_size_o | output | 12 | Total transfer size |
| inc_src_o | output | 1 | Source increment flag |
| inc_dst_o | output | 1 | Destination increment flag |
| src_sel_o | output | 1 | Source select flag |
| dst_sel_o | output | 1 | Destination select flag |
| chain_next_o | output | 1 | Load another descriptor when done |

## Verification
Every captured field changes on the clock edge where its read is completed, so it is due one cycle after the `rd_valid_i` beat. The bench's memory responder drives valid at a falling edge with a random 0 to 3 cycle wait. It checks the control fields at the following falling edge, while the fetch is still running. Pointer writes and non-descriptor starts are checked one cycle after their pulse. `done_o` is polled at falling edges, and the bench checks that it is gone one cycle later. At that point the pointer, addresses and the logged read-address order are compared against values computed from the bench's own memory function.

// File: rtl/desc_fetch_pkg.sv
package desc_fetch_pkg;
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned WORD_BYTES = 4;
  // control word bit positions
  localparam int unsigned CW_INC_SRC = 16;
  localparam int unsigned CW_INC_DST = 17;
  localparam int unsigned CW_SRC_SEL = 18;
  localparam int unsigned CW_DST_SEL = 19;
  localparam int unsigned CW_EOL     = 20;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_FETCH = 1'b1} fetch_st_t;

  typedef struct packed {
    logic inc_src;
    logic inc_dst;
    logic src_sel;
    logic dst_sel;
  } dir_flags_t;
endpackage

// File: rtl/desc_fetch_seq.sv
module desc_fetch_seq
  import desc_fetch_pkg::*;
#(
  parameter int unsigned NWORD = DESC_WORDS,
  localparam int unsigned IW = $clog2(NWORD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          rd_valid_i,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic          take_o,
  output logic          last_take_o,
  output logic          done_o
);
  fetch_st_t st_q;
  logic [IW-1:0] idx_q;
  logic done_q;

  assign busy_o      = (st_q == ST_FETCH);
  assign idx_o       = idx_q;
  assign take_o      = busy_o && rd_valid_i;
  assign last_take_o = take_o && (idx_q == IW'(NWORD - 1));
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_take_o;
      unique case (st_q)
        ST_IDLE: if (launch_i) begin
          st_q  <= ST_FETCH;
          idx_q <= '0;
        end
        ST_FETCH: if (take_o) begin
          if (last_take_o) st_q <= ST_IDLE;
          idx_q <= idx_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r2_launch_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && !busy_o) |=> (busy_o && idx_o == '0));
endmodule

// File: rtl/desc_fetch_regs.sv
module desc_fetch_regs
  import desc_fetch_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned SZW   = 12,
  parameter int unsigned NWORD = DESC_WORDS,
  localparam int unsigned IW = $clog2(NWORD)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           busy_i,
  input  logic           take_i,
  input  logic [IW-1:0]  idx_i,
  input  logic [AW-1:0]  data_i,
  input  logic           ptr_we_i,
  input  logic [AW-1:0]  ptr_wdata_i,
  input  logic           clr_chain_i,
  output logic [AW-1:0]  desc_ptr_o,
  output logic [AW-1:0]  cur_desc_o,
  output logic [AW-1:0]  src_addr_o,
  output logic [AW-1:0]  dst_addr_o,
  output logic [SZW-1:0] tot_size_o,
  output dir_flags_t     flags_o,
  output logic           chain_next_o
);
  logic [NWORD-1:0] wstb;

  for (genvar w = 0; w < NWORD; w++) begin : g_stb
    assign wstb[w] = take_i && (idx_i == IW'(w));
  end

  // word 0: control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tot_size_o   <= '0;
      flags_o      <= '0;
      chain_next_o <= 1'b0;
    end else if (wstb[0]) begin
      tot_size_o       <= data_i[SZW-1:0];
      flags_o.inc_src  <= data_i[CW_INC_SRC];
      flags_o.inc_dst  <= data_i[CW_INC_DST];
      flags_o.src_sel  <= data_i[CW_SRC_SEL];
      flags_o.dst_sel  <= data_i[CW_DST_SEL];
      chain_next_o     <= ~data_i[CW_EOL];
    end else if (clr_chain_i) begin
      chain_next_o <= 1'b0;
    end
  end

  // words 1 and 2: addresses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_addr_o <= '0;
      dst_addr_o <= '0;
    end else begin
      if (wstb[1]) src_addr_o <= data_i;
      if (wstb[2]) dst_addr_o <= data_i;
    end
  end

  // word 3: next pointer, remember consumed descriptor
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      desc_ptr_o <= '0;
      cur_desc_o <= '0;
    end else if (wstb[NWORD-1]) begin
      cur_desc_o <= desc_ptr_o;
      desc_ptr_o <= data_i;
    end else if (ptr_we_i && !busy_i) begin
      desc_ptr_o <= ptr_wdata_i;
    end
  end

  a_r9_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !wstb[NWORD-1]) |=> $stable(desc_ptr_o));
  a_r6_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> ($stable(src_addr_o) && $stable(dst_addr_o)));
  a_r7_cur_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wstb[NWORD-1] |=> (cur_desc_o == $past(desc_ptr_o)));
endmodule

// File: rtl/desc_fetch.sv
module desc_fetch
  import desc_fetch_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned SZW = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           desc_en_i,
  input  logic           ptr_we_i,
  input  logic [AW-1:0]  ptr_wdata_i,
  output logic           rd_req_o,
  output logic [AW-1:0]  rd_addr_o,
  input  logic           rd_valid_i,
  input  logic [AW-1:0]  rd_data_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [AW-1:0]  desc_ptr_o,
  output logic [AW-1:0]  cur_desc_o,
  output logic [AW-1:0]  src_addr_o,
  output logic [AW-1:0]  dst_addr_o,
  output logic [SZW-1:0] tot_size_o,
  output logic           inc_src_o,
  output logic           inc_dst_o,
  output logic           src_sel_o,
  output logic           dst_sel_o,
  output logic           chain_next_o
);
  localparam int unsigned NWORD = DESC_WORDS;
  localparam int unsigned IW    = $clog2(NWORD);
  localparam int unsigned SH    = $clog2(WORD_BYTES);

  logic          busy, take, last_take, launch, clr_chain;
  logic [IW-1:0] idx;
  dir_flags_t    flags;

  assign launch    = start_i && desc_en_i && !busy;
  assign clr_chain = start_i && !desc_en_i && !busy;

  desc_fetch_seq #(.NWORD(NWORD)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .rd_valid_i  (rd_valid_i),
    .busy_o      (busy),
    .idx_o       (idx),
    .take_o      (take),
    .last_take_o (last_take),
    .done_o      (done_o)
  );

  desc_fetch_regs #(.AW(AW), .SZW(SZW), .NWORD(NWORD)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy),
    .take_i       (take),
    .idx_i        (idx),
    .data_i       (rd_data_i),
    .ptr_we_i     (ptr_we_i),
    .ptr_wdata_i  (ptr_wdata_i),
    .clr_chain_i  (clr_chain),
    .desc_ptr_o   (desc_ptr_o),
    .cur_desc_o   (cur_desc_o),
    .src_addr_o   (src_addr_o),
    .dst_addr_o   (dst_addr_o),
    .tot_size_o   (tot_size_o),
    .flags_o      (flags),
    .chain_next_o (chain_next_o)
  );

  assign busy_o    = busy;
  assign rd_req_o  = busy;
  assign rd_addr_o = desc_ptr_o + (AW'(idx) << SH);
  assign inc_src_o = flags.inc_src;
  assign inc_dst_o = flags.inc_dst;
  assign src_sel_o = flags.src_sel;
  assign dst_sel_o = flags.dst_sel;

  a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));
  a_r8_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(start_i && desc_en_i)) |=> !rd_req_o);
  a_r8_chain_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !desc_en_i) |=> !chain_next_o);
  a_r2_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_take |=> (!busy_o && done_o));
endmodule

// File: tb/tb_desc_fetch.sv
module tb_desc_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, desc_en = 1'b0, ptr_we = 1'b0;
  logic [31:0] ptr_wdata = '0;
  logic        rd_req, rd_valid = 1'b0, busy, done;
  logic [31:0] rd_addr, rd_data = '0;
  logic [31:0] desc_ptr, cur_desc, src_addr, dst_addr;
  logic [11:0] tot_size;
  logic        inc_src, inc_dst, src_sel, dst_sel, chain_next;

  always #4 clk = ~clk;

  desc_fetch dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .desc_en_i(desc_en),
    .ptr_we_i(ptr_we), .ptr_wdata_i(ptr_wdata), .rd_req_o(rd_req),
    .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .busy_o(busy), .done_o(done), .desc_ptr_o(desc_ptr), .cur_desc_o(cur_desc),
    .src_addr_o(src_addr), .dst_addr_o(dst_addr), .tot_size_o(tot_size),
    .inc_src_o(inc_src), .inc_dst_o(inc_dst), .src_sel_o(src_sel),
    .dst_sel_o(dst_sel), .chain_next_o(chain_next)
  );

  int unsigned n_chk = 0, n_fail = 0;
  logic [31:0] salt = 32'h1234_5678;
  logic [31:0] ovr_base = '0, ovr_ctrl = '0;
  bit          ovr_en = 0;
  logic [31:0] log_a [8];
  int          log_n = 0;
  int          lat = 0;
  bit          ctrl_chk = 0;
  logic [31:0] exp_ctrl_q = '0;
  bit          finished = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (ovr_en && a == ovr_base) return ovr_ctrl;
    return ((a ^ 32'h5bd1_e995) * 32'h0100_0193) ^ salt;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // memory responder: random 0..3 cycle wait per word
  always @(negedge clk) begin
    rd_valid = 1'b0;
    if (ctrl_chk) begin
      ctrl_chk = 0;
      check(tot_size == exp_ctrl_q[11:0], "R4 size after ctrl beat",
            32'(tot_size), 32'(exp_ctrl_q[11:0]));
    end
    if (rd_req) begin
      if (lat == 0) begin
        rd_valid = 1'b1;
        rd_data  = mem_word(rd_addr);
        if (log_n < 8) log_a[log_n] = rd_addr;
        if (log_n == 0) begin ctrl_chk = 1; exp_ctrl_q = rd_data; end
        log_n++;
        lat = $urandom_range(0, 3);
      end else lat--;
    end
  end

  task automatic load_desc(input logic [31:0] p, input bit poke);
    logic [31:0] c;
    int guard;
    bit poked;
    @(negedge clk); ptr_we = 1; ptr_wdata = p;
    @(negedge clk); ptr_we = 0;
    check(desc_ptr == p, "R10 ptr write", desc_ptr, p);
    log_n = 0;
    start = 1; desc_en = 1;
    @(negedge clk); start = 0;
    check(busy == 1'b1, "R2 busy after start", 32'(busy), 32'd1);
    guard = 0; poked = 0;
    while (!done && guard < 100) begin
      if (poke && !poked && busy) begin
        ptr_we = 1; ptr_wdata = ~p; start = 1; poked = 1;
      end else begin
        ptr_we = 0; start = 0;
      end
      @(negedge clk); guard++;
    end
    ptr_we = 0; start = 0;
    c = mem_word(p);
    check(done == 1'b1, "R7 done seen", 32'(done), 32'd1);
    check(busy == 1'b0, "R7 idle at done", 32'(busy), 32'd0);
    check(log_n == 4, "R2 R9 read count", 32'(log_n), 32'd4);
    for (int i = 0; i < 4; i++)
      check(log_a[i] == p + 32'(4 * i), "R2 R3 read order", log_a[i], p + 32'(4 * i));
    check(tot_size == c[11:0], "R4 tot_size", 32'(tot_size), 32'(c[11:0]));
    check({dst_sel, src_sel, inc_dst, inc_src} == c[19:16], "R4 flags",
          32'({dst_sel, src_sel, inc_dst, inc_src}), 32'(c[19:16]));
    check(chain_next == ~c[20], "R5 chain", 32'(chain_next), 32'(~c[20]));
    check(src_addr == mem_word(p + 4), "R6 src", src_addr, mem_word(p + 4));
    check(dst_addr == mem_word(p + 8), "R6 dst", dst_addr, mem_word(p + 8));
    check(cur_desc == p, "R7 cur_desc", cur_desc, p);
    check(desc_ptr == mem_word(p + 12), "R7 R9 next ptr", desc_ptr, mem_word(p + 12));
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin : main
    logic [31:0] sv_src, sv_dst, sv_ptr;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(busy == 0 && rd_req == 0 && done == 0, "R1 control idle",
          32'({busy, rd_req, done}), 32'd0);
    check(desc_ptr == 0 && cur_desc == 0 && src_addr == 0 && dst_addr == 0,
          "R1 regs zero", desc_ptr | cur_desc | src_addr | dst_addr, 32'd0);
    check(tot_size == 0 && {inc_src, inc_dst, src_sel, dst_sel, chain_next} == 0,
          "R1 fields zero", 32'({tot_size, inc_src, inc_dst, src_sel, dst_sel, chain_next}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && rd_req == 0, "R1 idle after release", 32'({busy, rd_req}), 32'd0);

    // directed: not end of list, all flags set, max size
    ovr_en = 1; ovr_base = 32'h0000_1000; ovr_ctrl = 32'h000F_0FFF;
    load_desc(32'h0000_1000, 0);
    // R8: start without descriptor mode clears chain only
    sv_src = src_addr; sv_dst = dst_addr; sv_ptr = desc_ptr;
    log_n = 0;
    @(negedge clk); start = 1; desc_en = 0;
    @(negedge clk); start = 0;
    check(chain_next == 1'b0, "R8 chain cleared", 32'(chain_next), 32'd0);
    check(busy == 1'b0, "R8 no fetch", 32'(busy), 32'd0);
    @(negedge clk);
    check(log_n == 0, "R8 no reads", 32'(log_n), 32'd0);
    check(src_addr == sv_src && dst_addr == sv_dst && desc_ptr == sv_ptr,
          "R8 regs unchanged", desc_ptr, sv_ptr);
    // directed: end of list, zero flags, zero size
    ovr_base = 32'h0000_2000; ovr_ctrl = 32'h0010_0000;
    load_desc(32'h0000_2000, 0);
    // directed: pointer wrap at top of address space, with busy poke (R9)
    ovr_en = 0;
    load_desc(32'hFFFF_FFF8, 1);
    // random descriptors
    for (int k = 0; k < 24; k++) begin
      salt = $urandom;
      load_desc({$urandom} & 32'hFFFF_FFFC, k[0]);
    end
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end
endmodule